// File: doc/BRIEF.md
# Floating-point to signed integer truncator

This block turns one floating-point operand into a signed integer, always discarding the fractional part (rounding toward zero). The operand arrives as 64 raw bits together with a 2-bit code that names its precision (half, single or double) and a 1-bit select that picks a 32-bit or 64-bit result. One shared datapath serves all six combinations. It unpacks the operand, aligns the significand with a single left shift, saturates values that do not fit, and grades the outcome as exact, inexact or invalid.

A conversion is started by a one-cycle strobe. The registered result and an output valid appear on the next cycle. An invalid operation is reported in one of two ways. With the trap enable clear, it sets a sticky status bit. With the trap enable set, it raises a one-cycle trap request and leaves the status bit alone. Lost fraction bits always set a sticky inexact bit. Both sticky bits stay set until a synchronous clear.

Top module: `fp2int_trunc`

## Requirements
- R1: The result equals the operand's value with its fractional part dropped, for both signs (for example 4412.67 in double precision gives 4412, and -7.9 gives -7).
- R2: Format code 2'b11 reads a half-precision operand from bits [15:0], 2'b00 reads a single from [31:0], and 2'b01 reads a double from [63:0]. In each layout the sign is the top bit, then the biased exponent, then the fraction. Operand bits above the selected layout have no effect.
- R3: With the width select at 0, the 32-bit two's-complement result sits in out_int[31:0] and out_int[63:32] is zero. With it at 1, all 64 bits carry the result.
- R4: Format code 2'b10 is reserved. It gives a zero result and an invalid operation.
- R5: A NaN operand (exponent all ones, fraction nonzero) gives zero and an invalid operation.
- R6: Positive infinity, or a positive value at or above 2^(W-1), gives the largest W-bit signed value. Negative infinity, or a negative value below -2^(W-1), gives the smallest one. Both cases are invalid. Exactly -2^(W-1) converts without an exception.
- R7: A conversion that discards nonzero fraction bits is inexact. An invalid conversion is never reported as inexact.
- R8: Zero and subnormal operands of either sign give zero. A nonzero subnormal is inexact, and a zero is exact.
- R9: flag_invalid and flag_inexact are sticky and are cleared by flag_clr. When a clear and a new exception happen in the same cycle, the new exception sets the flag.
- R10: When trap_en is set, an invalid conversion pulses trap_req for exactly one cycle and does not set flag_invalid. When trap_en is clear, trap_req stays low.
- R11: out_valid is high in the cycle after each in_valid strobe and low otherwise. out_int holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Starts a conversion this cycle |
| in_bits | input | 64 | Raw floating-point operand |
| fmt_sel | input | 2 | Precision code (11 half, 00 single, 01 double, 10 reserved) |
| wide_sel | input | 1 | 0: 32-bit result, 1: 64-bit result |
| trap_en | input | 1 | Invalid operation raises a trap instead of a flag |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_int | output | 64 | Truncated signed integer |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_inexact | output | 1 | Sticky inexact flag |
| trap_req | output | 1 | One-cycle invalid-operation trap request |

## Verification
The bench builds the block with the package defaults: a 64-bit operand, a 53-bit aligned significand and a 64-bit result. With these values all three precisions and both result widths can be exercised in one run. Random operands have their exponent steered to just below, across and just above each width's saturation edge, so exact, inexact and saturating outcomes all occur often. Directed cases add the exact negative limits, infinities, NaN, subnormals, signed zero, the reserved code, the sticky clear and the trap path.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int OP_W  = 64;          // raw operand width
  localparam int SIG_W = 53;          // aligned significand incl. hidden bit
  localparam int EXP_W = 13;          // unbiased exponent, two's complement
  localparam int RES_W = 64;          // widest integer result
  localparam int NARROW_W = RES_W / 2;
  localparam int SH_W  = $clog2(RES_W);

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_RSV = 2'b10,
    FMT_HLF = 2'b11
  } fmt_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;     // unbiased
    logic [SIG_W-1:0] sig;     // 1.fraction, left aligned
    logic             nan;
    logic             inf;
    logic             zsub;    // zero or subnormal
    logic             sub_nz;  // nonzero subnormal
    logic             bad;     // reserved format code
  } unpk_t;

  // Places the significand so that the integer part lands in the top
  // RES_W bits of the window; returns {fraction_lost, magnitude}.
  function automatic logic [RES_W:0] shift_int(input logic [SIG_W-1:0] sig,
                                               input logic [SH_W-1:0]  e);
    logic [SIG_W+RES_W-1:0] win;
    win = {{RES_W{1'b0}}, sig} << e;
    return {|win[SIG_W-2:0], win[SIG_W+RES_W-2:SIG_W-1]};
  endfunction

  // Largest magnitude that a result of the chosen width may reach (2^(W-1)).
  function automatic logic [RES_W-1:0] lim_of(input logic wide);
    return wide ? (RES_W'(1) << (RES_W-1)) : (RES_W'(1) << (NARROW_W-1));
  endfunction
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [OP_W-1:0] op_bits,
  input  logic [1:0]      fmt_sel,
  output unpk_t           fields
);
  // One layout per precision: exponent width, fraction width, bias.
  function automatic unpk_t split_fp(input logic [OP_W-1:0] b, input logic [1:0] f);
    unpk_t u;
    u = '0;
    case (fmt_e'(f))
      FMT_HLF: begin
        u.sign   = b[15];
        u.exp    = EXP_W'(b[14:10]) - EXP_W'(15);
        u.sig    = {1'b1, b[9:0], {(SIG_W-11){1'b0}}};
        u.nan    = (&b[14:10]) && (|b[9:0]);
        u.inf    = (&b[14:10]) && !(|b[9:0]);
        u.zsub   = !(|b[14:10]);
        u.sub_nz = !(|b[14:10]) && (|b[9:0]);
      end
      FMT_SGL: begin
        u.sign   = b[31];
        u.exp    = EXP_W'(b[30:23]) - EXP_W'(127);
        u.sig    = {1'b1, b[22:0], {(SIG_W-24){1'b0}}};
        u.nan    = (&b[30:23]) && (|b[22:0]);
        u.inf    = (&b[30:23]) && !(|b[22:0]);
        u.zsub   = !(|b[30:23]);
        u.sub_nz = !(|b[30:23]) && (|b[22:0]);
      end
      FMT_DBL: begin
        u.sign   = b[63];
        u.exp    = EXP_W'(b[62:52]) - EXP_W'(1023);
        u.sig    = {1'b1, b[51:0]};
        u.nan    = (&b[62:52]) && (|b[51:0]);
        u.inf    = (&b[62:52]) && !(|b[51:0]);
        u.zsub   = !(|b[62:52]);
        u.sub_nz = !(|b[62:52]) && (|b[51:0]);
      end
      default: u.bad = 1'b1;
    endcase
    return u;
  endfunction

  assign fields = split_fp(op_bits, fmt_sel);
endmodule

// File: rtl/fp2int_sat.sv
module fp2int_sat
  import fp2int_pkg::*;
(
  input  unpk_t            fields,
  input  logic             wide_sel,
  output logic [RES_W-1:0] res,
  output logic             invalid,
  output logic             inexact,
  output logic             ovf
);
  logic [RES_W-1:0] mag, lim, val;
  logic             lost, frac_only, big;

  assign {lost, mag} = shift_int(fields.sig, fields.exp[SH_W-1:0]);
  assign lim       = lim_of(wide_sel);
  assign frac_only = fields.exp[EXP_W-1];                        // |value| < 1
  assign big       = !fields.exp[EXP_W-1] && (|fields.exp[EXP_W-2:SH_W]);

  always_comb begin
    ovf = !fields.nan && !fields.bad && !fields.zsub &&
          (fields.inf || big ||
           (!frac_only && (fields.sign ? (mag > lim) : (mag >= lim))));
    invalid = fields.bad || fields.nan || ovf;
    inexact = !invalid && !fields.inf &&
              (fields.zsub ? fields.sub_nz : (frac_only || lost));
    val = fields.sign ? (~mag + RES_W'(1)) : mag;
    if (fields.bad || fields.nan || fields.zsub || (frac_only && !ovf))
      res = '0;
    else if (ovf)
      res = fields.sign ? lim : (lim - RES_W'(1));
    else if (wide_sel)
      res = val;
    else
      res = {{(RES_W-NARROW_W){1'b0}}, val[NARROW_W-1:0]};
  end
endmodule

// File: rtl/fp2int_trunc.sv
module fp2int_trunc
  import fp2int_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_bits,
  input  logic [1:0]       fmt_sel,
  input  logic             wide_sel,
  input  logic             trap_en,
  input  logic             flag_clr,
  output logic             out_valid,
  output logic [RES_W-1:0] out_int,
  output logic             flag_invalid,
  output logic             flag_inexact,
  output logic             trap_req
);
  unpk_t            fields;
  logic [RES_W-1:0] cv_res;
  logic             cv_inv, cv_inx, cv_ovf;

  fp2int_unpack u_unpack (.op_bits(in_bits), .fmt_sel(fmt_sel), .fields(fields));
  fp2int_sat    u_sat    (.fields(fields), .wide_sel(wide_sel), .res(cv_res),
                          .invalid(cv_inv), .inexact(cv_inx), .ovf(cv_ovf));

  // Named events for the flag and trap logic and for the checks below.
  logic ev_inv_flag, ev_inv_trap, ev_inx, ev_nan;
  assign ev_inv_flag = in_valid && cv_inv && !trap_en;
  assign ev_inv_trap = in_valid && cv_inv &&  trap_en;
  assign ev_inx      = in_valid && cv_inx;
  assign ev_nan      = in_valid && fields.nan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_int      <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      trap_req     <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      if (in_valid) out_int <= cv_res;
      flag_invalid <= (flag_invalid && !flag_clr) || ev_inv_flag;
      flag_inexact <= (flag_inexact && !flag_clr) || ev_inx;
      trap_req     <= ev_inv_trap;
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_int));
  a_r7_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_inv && cv_inx));
  a_r5_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nan |=> (out_int == '0));
  a_r6_ovf_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cv_ovf && !trap_en) |=> flag_invalid);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_invalid && !flag_clr) |=> flag_invalid);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> (!flag_invalid && !flag_inexact));
  a_r10_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(in_valid && trap_en));
  a_r10_no_flag_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !$rose(flag_invalid));
endmodule

// File: tb/fp2int_trunc_bench.sv
module fp2int_trunc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        wide_sel = 1'b0;
  logic        trap_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic        out_valid, flag_invalid, flag_inexact, trap_req;
  logic [63:0] out_int;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  fp2int_trunc u_fp2int_trunc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .fmt_sel(fmt_sel), .wide_sel(wide_sel), .trap_en(trap_en),
    .flag_clr(flag_clr), .out_valid(out_valid), .out_int(out_int),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .trap_req(trap_req));

  always #10 clk = ~clk;   // 50 MHz

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired got=%0d expected<=150000", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, expv);
    end
  endtask

  // Layout of each precision: exponent bits, fraction bits, bias.
  function automatic void geom(input logic [1:0] f, output int ew, output int fw, output int bias);
    case (f)
      2'b11:   begin ew = 5;  fw = 10; bias = 15;   end
      2'b00:   begin ew = 8;  fw = 23; bias = 127;  end
      default: begin ew = 11; fw = 52; bias = 1023; end
    endcase
  endfunction

  // Reference: value is (2^fw + frac) * 2^(e - bias - fw); shift right or left.
  function automatic void ref_conv(input logic [63:0] b, input logic [1:0] f, input logic w,
                                   output logic [63:0] r, output logic inv, output logic inx);
    int ew, fw, bias, e, ee;
    longint unsigned fr, m, mag, hi;
    logic s;
    r = '0; inv = 1'b0; inx = 1'b0;
    hi  = w ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    if (f == 2'b10) begin inv = 1'b1; return; end
    geom(f, ew, fw, bias);
    fr = b & ((64'd1 << fw) - 1);
    e  = int'((b >> fw) & ((64'd1 << ew) - 1));
    s  = b[ew + fw];
    if (e == (1 << ew) - 1) begin
      inv = 1'b1;
      if (fr == 0) r = s ? hi : hi - 1;
      return;
    end
    if (e == 0) begin inx = (fr != 0); return; end
    ee = e - bias;
    m  = (64'd1 << fw) | fr;
    if (ee < 0) begin inx = 1'b1; return; end
    if (ee >= 64) begin inv = 1'b1; r = s ? hi : hi - 1; return; end
    if (ee <= fw) begin
      mag = m >> (fw - ee);
      inx = ((m & ((64'd1 << (fw - ee)) - 1)) != 0);
    end else mag = m << (ee - fw);
    if (s ? (mag > hi) : (mag >= hi)) begin
      inv = 1'b1; inx = 1'b0; r = s ? hi : hi - 1; return;
    end
    r = s ? (~mag + 64'd1) : mag;
    if (!w) r = {32'd0, r[31:0]};
  endfunction

  // Drives one conversion; flags are cleared in the same cycle, so the
  // sampled flags reflect this conversion alone (R9: event wins over clear).
  task automatic conv(input string tag, input logic [63:0] b, input logic [1:0] f,
                      input logic w, input logic tr, input logic clr,
                      output logic [63:0] r, output logic inv, output logic inx);
    @(negedge clk);
    in_valid = 1'b1; in_bits = b; fmt_sel = f; wide_sel = w; trap_en = tr; flag_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    r = out_int; inv = flag_invalid; inx = flag_inexact;
    chk({tag, " R11 out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " R10 trap_req"}, {63'd0, trap_req}, 64'(tr && (f == 2'b10 || inv || trap_req)) & {63'd0, trap_req});
  endtask

  task automatic conv_ref(input string tag, input logic [63:0] b, input logic [1:0] f,
                          input logic w, input logic tr);
    logic [63:0] r, er; logic inv, inx, ei, ex;
    ref_conv(b, f, w, er, ei, ex);
    conv(tag, b, f, w, tr, 1'b1, r, inv, inx);
    chk({tag, " result"}, r, er);
    chk({tag, " R10 flag_invalid"}, {63'd0, inv}, {63'd0, ei && !tr});
    chk({tag, " R10 trap_req"}, {63'd0, trap_req}, {63'd0, ei && tr});
    chk({tag, " R7 flag_inexact"}, {63'd0, inx}, {63'd0, ex});
  endtask

  task automatic direct(input string tag, input logic [63:0] b, input logic [1:0] f,
                        input logic w, input logic [63:0] er, input logic ei, input logic ex);
    logic [63:0] r; logic inv, inx;
    conv(tag, b, f, w, 1'b0, 1'b1, r, inv, inx);
    chk({tag, " result"}, r, er);
    chk({tag, " invalid"}, {63'd0, inv}, {63'd0, ei});
    chk({tag, " inexact"}, {63'd0, inx}, {63'd0, ex});
  endtask

  initial begin
    logic [63:0] r; logic inv, inx;
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset flags", {62'd0, flag_invalid, flag_inexact}, 64'd0);
    chk("R10 reset trap_req", {63'd0, trap_req}, 64'd0);
    rst_n = 1'b1;

    direct("R1 4412.67 d->32", $realtobits(4412.67), 2'b01, 1'b0, 64'd4412, 1'b0, 1'b1);
    direct("R1 -7.9 d->32", $realtobits(-7.9), 2'b01, 1'b0, 64'h0000_0000_FFFF_FFF9, 1'b0, 1'b1);
    direct("R3 -7.9 d->64", $realtobits(-7.9), 2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 1'b1);
    direct("R2 half 10.0 upper junk", 64'hDEAD_BEEF_0000_4900, 2'b11, 1'b0, 64'd10, 1'b0, 1'b0);
    direct("R2 half -1.5", 64'h0000_0000_0000_BE00, 2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    direct("R2 single 1.0 upper junk", 64'h1234_5678_3F80_0000, 2'b00, 1'b0, 64'd1, 1'b0, 1'b0);
    direct("R6 single 2^31 ->32 sat", 64'h4F00_0000, 2'b00, 1'b0, 64'h7FFF_FFFF, 1'b1, 1'b0);
    direct("R6 single -2^31 ->32 exact", 64'hCF00_0000, 2'b00, 1'b0, 64'h8000_0000, 1'b0, 1'b0);
    direct("R6 double 2^63 ->64 sat", 64'h43E0_0000_0000_0000, 2'b01, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    direct("R6 double -2^63 ->64 exact", 64'hC3E0_0000_0000_0000, 2'b01, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    direct("R6 -inf ->32", 64'hFFF0_0000_0000_0000, 2'b01, 1'b0, 64'h8000_0000, 1'b1, 1'b0);
    direct("R6 +inf half ->64", 64'h7C00, 2'b11, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    direct("R5 NaN", 64'h7FF8_0000_0000_0001, 2'b01, 1'b1, 64'd0, 1'b1, 1'b0);
    direct("R4 reserved fmt", 64'h4000_0000_0000_0000, 2'b10, 1'b1, 64'd0, 1'b1, 1'b0);
    direct("R8 subnormal", 64'h0000_0000_0000_0001, 2'b01, 1'b1, 64'd0, 1'b0, 1'b1);
    direct("R8 minus zero", 64'h8000_0000_0000_0000, 2'b01, 1'b0, 64'd0, 1'b0, 1'b0);
    direct("R7 single 0.5", 64'h3F00_0000, 2'b00, 1'b0, 64'd0, 1'b0, 1'b1);

    // R10: trapped NaN pulses trap_req only, for one cycle.
    conv("R10 trap", 64'h7FF8_0000_0000_0000, 2'b01, 1'b0, 1'b1, 1'b1, r, inv, inx);
    chk("R10 trap_req high", {63'd0, trap_req}, 64'd1);
    chk("R10 no invalid flag", {63'd0, inv}, 64'd0);
    @(negedge clk);
    chk("R10 trap_req one cycle", {63'd0, trap_req}, 64'd0);

    // R9 sticky, R11 hold
    conv("R9 first", 64'h3FC0_0000, 2'b00, 1'b0, 1'b0, 1'b1, r, inv, inx);
    chk("R9 inexact set", {63'd0, inx}, 64'd1);
    conv("R9 second", 64'h4000_0000, 2'b00, 1'b0, 1'b0, 1'b0, r, inv, inx);
    chk("R9 exact result", r, 64'd2);
    chk("R9 inexact sticky", {63'd0, inx}, 64'd1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 cleared", {62'd0, flag_invalid, flag_inexact}, 64'd0);
    chk("R11 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 out_int held", out_int, 64'd2);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] f; logic w, tr; logic [63:0] b;
      int ew, fw, bias, e, sel;
      sel = int'($urandom_range(0, 2));
      f = (sel == 0) ? 2'b11 : (sel == 1) ? 2'b00 : 2'b01;
      w = 1'($urandom); tr = ($urandom_range(0, 7) == 0);
      b = {$urandom, $urandom};
      geom(f, ew, fw, bias);
      if ($urandom_range(0, 7) != 0) begin
        e = bias - 4 + int'($urandom_range(0, w ? 70 : 38));
        if (e > (1 << ew) - 1) e = (1 << ew) - 1;
        b = (b & ~(((64'd1 << ew) - 1) << fw)) | (64'(e) << fw);
      end
      conv_ref("R1 random", b, f, w, tr);
    end
    done = 1'b1;
    report();
  end
endmodule